// File: doc/BRIEF.md
# Reconfigurable Fixed-Width Booth Multiplier Engine

This block is a signed radix-4 Booth multiplier for two N-bit operands (N = 8 by default). A two-bit operation code reshapes a single truncated partial-product fabric into one of four functions. It can form one N×N product truncated to N bits. It can form two independent half-width truncated products side by side. It can form one exact half-width product. It can also add two half-width truncated products together. The partial-product rows are split between two arrays. The lower array holds the rows driven by the low multiplier half. The upper array holds the rows driven by the high multiplier half. A decoder turns the operation code into configuration lines. Those lines choose the multiplicand each array sees, gate the Booth encoders, choose where the low-order columns are cut off, and steer the compensation bits and the output halves. The result is registered, so it appears one clock after the operands.

Operand halves are written X1 = x[N-1:N/2], X0 = x[N/2-1:0], Y1 = y[N-1:N/2] and Y0 = y[N/2-1:0]. Each half is read as a signed two's-complement number.

The truncated product F_n(a, b, c) of two signed n-bit values is defined as follows. Recode b into radix-4 Booth digits D_i = -2·b[2i+1] + b[2i] + b[2i-1] for i = 0 … n/2-1, taking b[-1] = 0. For each row, take floor(D_i·a·4^i / 2^(n-1)). Sum these over all rows, add the compensation bit c, and take floor of half that sum. The function k(b) is 1 when D_0 of b is nonzero, and 0 otherwise.

Top module: `rfw_booth_engine`

## Requirements
- R1: While rst is high at a rising clock edge, p_o is all zeros after that edge.
- R2: p_o after rising edge k depends only on op_i, x_i and y_i sampled at edge k. The operation code may change on every cycle.
- R3: With op_i = 00, p_o = F_N(x, y, c) mod 2^N, where c = 1 only when Booth digits D_0 and D_{N/4} of y (D_{N/4} using y[N/2-1] as its lookback bit) are both nonzero.
- R4: With op_i = 01, p_o[N/2-1:0] = F_{N/2}(X1, Y0, k(Y0)) mod 2^(N/2).
- R5: With op_i = 01, p_o[N-1:N/2] = F_{N/2}(X0, Y1, k(Y1)) mod 2^(N/2). The lowest Booth digit of Y1 uses lookback 0, so y[N/2-1] does not reach this half.
- R6: With op_i = 10, p_o = X1·Y1 exactly, as an N-bit two's-complement value. x[N/2-1:0] and y[N/2-1:0] have no effect.
- R7: With op_i = 11, p_o is the sum mod 2^N of the R4 nibble and the R5 nibble, each sign-extended from N/2 bits.
- R8: In the op_i = 00 mode the half-LSB compensation is added at most once. The lower-array and upper-array estimates are combined by AND and are never summed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Mode: 00 full truncated, 01 paired halves, 10 exact half, 11 sum of halves |
| x_i | input | N | Multiplicand, signed, or two signed halves |
| y_i | input | N | Multiplier, signed, or two signed halves |
| p_o | output | N | Registered result |

## Verification
The clocked properties assume that op_i, x_i and y_i are stable around each rising edge. They also assume that reset is held at least one edge before the first operation. The bench respects both: it changes the inputs only on falling edges and starts with reset high for several cycles. The range properties on the half-width and full-width sums depend on the operands being true two's-complement values. The paired-half and summed modes are swept over every 16-bit operand combination. The exact mode is swept over every pair of upper halves while the lower halves move. The full mode and mixed mode sequences use random operands.

// File: rtl/rfw_pkg.sv
`timescale 1ns/1ps
package rfw_pkg;

  typedef enum logic [1:0] {
    MODE_FULL  = 2'b00,
    MODE_PAIR  = 2'b01,
    MODE_EXACT = 2'b10,
    MODE_SUM   = 2'b11
  } mode_e;

  // configuration lines, msb first: sum select, exact, split, whole
  typedef struct packed {
    logic sum_sel;
    logic exact;
    logic split;
    logic whole;
  } cfg_t;

  // one Booth row selection: negate, select 1x, select 2x
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bsel_t;

endpackage

// File: rtl/rfw_mode_dec.sv
`timescale 1ns/1ps
module rfw_mode_dec
  import rfw_pkg::*;
(
  input  mode_e op_i,
  output cfg_t  cfg_o
);
  always_comb begin
    case (op_i)
      MODE_FULL:  cfg_o = 4'b0001;
      MODE_PAIR:  cfg_o = 4'b0010;
      MODE_EXACT: cfg_o = 4'b0100;
      default:    cfg_o = 4'b1010;
    endcase
  end
endmodule

// File: rtl/rfw_booth_enc.sv
`timescale 1ns/1ps
module rfw_booth_enc
  import rfw_pkg::*;
(
  input  logic [2:0] trip_i,   // {b[2i+1], b[2i], b[2i-1]}
  output bsel_t      sel_o
);
  logic hi, mid, lo;
  assign {hi, mid, lo} = trip_i;
  assign sel_o.one = mid ^ lo;
  assign sel_o.two = (hi & ~mid & ~lo) | (~hi & mid & lo);
  assign sel_o.neg = hi & ~(mid & lo);
endmodule

// File: rtl/rfw_row_array.sv
`timescale 1ns/1ps
module rfw_row_array
  import rfw_pkg::*;
#(
  parameter int unsigned AW   = 8,
  parameter int unsigned ROWS = 2,
  parameter int unsigned SW   = 20,
  parameter int unsigned SHW  = 6
) (
  input  logic signed [AW-1:0]   mcand_i,
  input  bsel_t [ROWS-1:0]       sel_i,
  input  logic [SHW-1:0]         base_i,
  input  logic [SHW-1:0]         trunc_i,
  output logic signed [SW-1:0]   sum_o
);
  logic signed [SW-1:0] ext;
  assign ext = {{(SW-AW){mcand_i[AW-1]}}, mcand_i};

  // each row is weighted, then floored at the cut column before summing
  always_comb begin
    logic signed [SW-1:0] mag;
    logic signed [SW-1:0] val;
    sum_o = '0;
    for (int r = 0; r < ROWS; r++) begin
      mag   = sel_i[r].two ? (ext <<< 1) : (sel_i[r].one ? ext : '0);
      val   = sel_i[r].neg ? -mag : mag;
      sum_o = sum_o + ((val <<< (base_i + SHW'(2 * r))) >>> trunc_i);
    end
  end
endmodule

// File: rtl/rfw_comp.sv
`timescale 1ns/1ps
module rfw_comp
  import rfw_pkg::*;
(
  input  cfg_t  cfg_i,
  input  bsel_t row_lo_i,
  input  bsel_t row_hi_i,
  output logic  scc_lo_o,
  output logic  scc_hi_o
);
  logic km_lo, km_hi;
  assign km_lo = row_lo_i.one | row_lo_i.two;
  assign km_hi = row_hi_i.one | row_hi_i.two;

  always_comb begin
    scc_lo_o = 1'b0;
    scc_hi_o = 1'b0;
    if (cfg_i.whole) begin
      scc_lo_o = km_lo & km_hi;
    end else if (cfg_i.split) begin
      scc_lo_o = km_lo;
      scc_hi_o = km_hi;
    end
  end
endmodule

// File: rtl/rfw_booth_engine.sv
`timescale 1ns/1ps
module rfw_booth_engine
  import rfw_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op_i,
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  output logic [N-1:0] p_o
);
  localparam int unsigned H    = N / 2;
  localparam int unsigned ROWS = N / 4;
  localparam int unsigned SW   = 2 * N + 4;
  localparam int unsigned SHW  = $clog2(SW) + 1;

  cfg_t cfg;
  rfw_mode_dec u_dec (.op_i(mode_e'(op_i)), .cfg_o(cfg));

  // multiplier bits: lower half cleared in exact mode, upper lookback only in whole mode
  logic [H-1:0] y_lo;
  logic [H:0]   y_lo_x, y_hi_x;
  assign y_lo   = cfg.exact ? '0 : y_i[H-1:0];
  assign y_lo_x = {y_lo, 1'b0};
  assign y_hi_x = {y_i[N-1:H], cfg.whole & y_i[H-1]};

  bsel_t [ROWS-1:0] sel_lo, sel_hi;
  for (genvar r = 0; r < ROWS; r++) begin : g_enc
    rfw_booth_enc u_lo (.trip_i(y_lo_x[2*r+2 -: 3]), .sel_o(sel_lo[r]));
    rfw_booth_enc u_hi (.trip_i(y_hi_x[2*r+2 -: 3]), .sel_o(sel_hi[r]));
  end

  // multiplicand steering: cross halves in subword modes
  logic signed [N-1:0] x_top_ext, x_bot_ext, mc_lo, mc_hi;
  assign x_top_ext = {{H{x_i[N-1]}}, x_i[N-1:H]};
  assign x_bot_ext = {{H{x_i[H-1]}}, x_i[H-1:0]};
  assign mc_lo = cfg.whole ? x_i : x_top_ext;
  assign mc_hi = cfg.whole ? x_i : (cfg.exact ? x_top_ext : x_bot_ext);

  logic [SHW-1:0] sh_hi, cut;
  assign sh_hi = cfg.whole ? SHW'(H) : '0;
  assign cut   = cfg.whole ? SHW'(N - 1) : (cfg.exact ? '0 : SHW'(H - 1));

  logic signed [SW-1:0] sum_lo, sum_hi;
  rfw_row_array #(.AW(N), .ROWS(ROWS), .SW(SW), .SHW(SHW)) u_arr_lo (
    .mcand_i(mc_lo), .sel_i(sel_lo), .base_i({SHW{1'b0}}), .trunc_i(cut), .sum_o(sum_lo)
  );
  rfw_row_array #(.AW(N), .ROWS(ROWS), .SW(SW), .SHW(SHW)) u_arr_hi (
    .mcand_i(mc_hi), .sel_i(sel_hi), .base_i(sh_hi), .trunc_i(cut), .sum_o(sum_hi)
  );

  logic scc_lo, scc_hi;
  rfw_comp u_comp (
    .cfg_i(cfg), .row_lo_i(sel_lo[0]), .row_hi_i(sel_hi[0]),
    .scc_lo_o(scc_lo), .scc_hi_o(scc_hi)
  );

  logic signed [SW-1:0] c_lo, c_hi, s_all, fw_lo, fw_hi;
  assign c_lo  = $signed({{(SW-1){1'b0}}, scc_lo});
  assign c_hi  = $signed({{(SW-1){1'b0}}, scc_hi});
  assign s_all = sum_lo + sum_hi + c_lo + c_hi;
  assign fw_lo = (sum_lo + c_lo) >>> 1;
  assign fw_hi = (sum_hi + c_hi) >>> 1;

  logic [N-1:0] p_next, sum_pair;
  assign sum_pair = {{H{fw_lo[H-1]}}, fw_lo[H-1:0]} + {{H{fw_hi[H-1]}}, fw_hi[H-1:0]};

  always_comb begin
    case ({cfg.split, cfg.sum_sel})
      2'b10:   p_next = {fw_hi[H-1:0], fw_lo[H-1:0]};
      2'b11:   p_next = sum_pair;
      default: p_next = cfg.exact ? s_all[N-1:0] : s_all[N:1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) p_o <= '0;
    else     p_o <= p_next;
  end

  // ---------------- assertions ----------------
  logic signed [N-1:0] chk_exact;
  assign chk_exact = $signed(x_top_ext) * $signed({{H{y_i[N-1]}}, y_i[N-1:H]});

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (p_o == '0));

  p_exact_product_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'b10) |=> (p_o == $past(chk_exact)));

  p_lower_idle_r6: assert property (@(posedge clk) disable iff (rst)
    cfg.exact |-> (sum_lo == '0));

  p_single_bias_r8: assert property (@(posedge clk) disable iff (rst)
    cfg.whole |-> !(scc_lo && scc_hi));

  p_full_range_r3: assert property (@(posedge clk) disable iff (rst)
    cfg.whole |-> ((s_all >= -(2 ** N)) && (s_all < (2 ** N))));

  p_half_range_r7: assert property (@(posedge clk) disable iff (rst)
    cfg.split |-> ((fw_lo >= -(2 ** (H-1))) && (fw_lo < (2 ** (H-1))) &&
                   (fw_hi >= -(2 ** (H-1))) && (fw_hi < (2 ** (H-1)))));
endmodule

// File: tb/rfw_booth_engine_tb_top.sv
`timescale 1ns/1ps
module rfw_booth_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op  = 2'b00;
  logic [7:0] x   = 8'h00;
  logic [7:0] y   = 8'h00;
  logic [7:0] p;

  always #10 clk = ~clk;   // 50 MHz

  rfw_booth_engine #(.N(8)) dut_i (
    .clk(clk), .rst(rst), .op_i(op), .x_i(x), .y_i(y), .p_o(p)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    pend    = 1'b0;
  int    pend_exp;
  string pend_tag;

  function automatic int sx(int v, int w);
    int m;
    m = v & ((1 << w) - 1);
    return (m >= (1 << (w - 1))) ? m - (1 << w) : m;
  endfunction

  function automatic int bdig(int b, int i);
    int hi, mid, lo;
    hi  = (b >>> (2*i + 1)) & 1;
    mid = (b >>> (2*i)) & 1;
    lo  = (i == 0) ? 0 : ((b >>> (2*i - 1)) & 1);
    return -2*hi + mid + lo;
  endfunction

  function automatic int ftr(int a, int b, int n, int c);
    int s;
    s = 0;
    for (int i = 0; i < n/2; i++) s += (bdig(b, i) * a * (1 << (2*i))) >>> (n - 1);
    return (s + c) >>> 1;
  endfunction

  function automatic int nib_lo(int xv, int yv);   // R4
    return ftr(sx(xv >> 4, 4), sx(yv, 4), 4, int'(bdig(sx(yv, 4), 0) != 0)) & 15;
  endfunction

  function automatic int nib_hi(int xv, int yv);   // R5
    return ftr(sx(xv, 4), sx(yv >> 4, 4), 4, int'(bdig(sx(yv >> 4, 4), 0) != 0)) & 15;
  endfunction

  function automatic int model(int m, int xv, int yv);
    int b, c;
    case (m)
      0: begin   // R3, R8
        b = sx(yv, 8);
        c = int'(bdig(b, 0) != 0 && bdig(b, 2) != 0);
        return ftr(sx(xv, 8), b, 8, c) & 255;
      end
      1: return (nib_hi(xv, yv) << 4) | nib_lo(xv, yv);
      2: return (sx(xv >> 4, 4) * sx(yv >> 4, 4)) & 255;   // R6
      default: return (sx(nib_lo(xv, yv), 4) + sx(nib_hi(xv, yv), 4)) & 255;   // R7
    endcase
  endfunction

  task automatic check(int got, int exp, string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(int m, int xv, int yv, string tag);
    @(negedge clk);
    if (pend) check(int'(p), pend_exp, pend_tag);
    op = 2'(m); x = 8'(xv); y = 8'(yv);
    pend_exp = model(m, xv, yv);
    pend_tag = tag;
    pend = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) check(int'(p), pend_exp, pend_tag);
    pend = 1'b0;
  endtask

  initial begin
    #(20 * 195000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    op = 2'b01; x = 8'hA5; y = 8'h3C;
    repeat (3) @(negedge clk);
    check(int'(p), 0, "R1 reset state");
    rst = 1'b0;

    // directed corners
    step(2, 8'h80, 8'h80, "R6 most negative halves");
    step(2, 8'h7F, 8'h8F, "R6 mixed signs");
    step(0, 8'h7F, 8'h7F, "R3 max positive");
    step(0, 8'h80, 8'h80, "R3 most negative");
    step(0, 8'h55, 8'h09, "R8 both estimates set");
    step(0, 8'h55, 8'h01, "R8 upper estimate clear");
    step(1, 8'h8F, 8'h78, "R5 lookback ignored");
    step(1, 8'h8F, 8'h70, "R5 lookback ignored");
    step(3, 8'h88, 8'h88, "R7 corner");
    flush();

    // R4 R5 exhaustive paired halves
    for (int v = 0; v < 65536; v++) step(1, v >> 8, v & 255, "R4 R5 paired halves");
    // R7 exhaustive sum of halves
    for (int v = 0; v < 65536; v++) step(3, v >> 8, v & 255, "R7 sum of halves");
    // R6 exact: every upper-half pair, lower halves varying
    for (int v = 0; v < 256; v++)
      step(2, ((v >> 4) << 4) | ((v * 7) & 15), ((v & 15) << 4) | ((v * 11) & 15),
           "R6 exact half");
    // R3 R8 random full-width
    for (int i = 0; i < 20000; i++)
      step(0, int'($urandom_range(255)), int'($urandom_range(255)), "R3 R8 full width");
    // R2 mode changes every cycle
    for (int i = 0; i < 2000; i++)
      step(int'($urandom_range(3)), int'($urandom_range(255)), int'($urandom_range(255)),
           "R2 per-cycle mode switch");
    flush();

    // R1 reset again with busy inputs
    op = 2'b11; x = 8'h7E; y = 8'hC3;
    rst = 1'b1;
    @(negedge clk);
    check(int'(p), 0, "R1 reset mid-run");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule